// File: doc/BRIEF.md
# Interval Timer Channel with System Control Port

This block is one down-counting interval timer channel. It is programmed over a byte-wide I/O bus. A control-word write arms the channel in "interrupt on terminal count" mode with binary counting and low-then-high byte access. Two writes to the data port then load a 16-bit interval, low byte first. A separate system control port does three jobs: it gates the reference clock into the counter, it lets the timer output drive a speaker pin, and it reports the current timer output level in a read-only status bit. Software polls that bit to find out when the interval has elapsed.

The counter advances on the reference tick enable (a 1193182 Hz rate in a typical system), and only while the gate bit is set. The timer output drops low when the channel is armed. It rises after the programmed number of gated ticks and stays high until the channel is rewritten. The control flow has five states:

- `ST_IDLE`: after reset. A valid control word moves it to `ST_WAIT_LO`.
- `ST_WAIT_LO`: the low byte is expected. A data write moves it to `ST_WAIT_HI`.
- `ST_WAIT_HI`: the high byte is expected. A data write loads the counter and moves it to `ST_COUNT`.
- `ST_COUNT`: a gated tick at count one moves it to `ST_DONE`. A data write returns it to `ST_WAIT_HI`.
- `ST_DONE`: the output is high. A data write returns it to `ST_WAIT_HI`.

From every state except `ST_IDLE`, a valid control word returns the channel to `ST_WAIT_LO`.

Top module: `interval_timer`

## Requirements
- R1: After reset the timer output is low, the speaker pin is low and a read of the system control port (address 2) returns 0x00.
- R2: Only the value 0xB0 written to the control port (address 1) is accepted. It drives the output low and starts a new two-byte load. Any other control value leaves the output and the count untouched.
- R3: The count is written to the data port (address 0), low byte first and then high byte. Data writes made before any accepted control word have no effect, and the output stays low.
- R4: With the gate set, the output rises on the Nth reference tick after the high-byte write, where N is the loaded count. A tick in the same cycle as the high-byte write is not counted.
- R5: While gate bit 0 of the system control port is clear, ticks do not advance the count, and counting resumes from where it stopped.
- R6: A loaded count of 0 acts as 65536 ticks.
- R7: Once high, the output stays high through further ticks until a new control word or data write arrives. A low-byte write drops the output low and halts counting until the high byte arrives.
- R8: Bit 1 of the system control port enables the speaker pin, which carries the timer output AND that bit.
- R9: System control port bits other than bit 5 read back as last written. Bit 5 reads the current timer output level and ignores writes.
- R10: Reads of the data and control ports return 0x00, and the read bus is 0x00 whenever the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Reference tick enable, one cycle per counter tick |
| bus_addr | input | 2 | Port select: 0 data, 1 control word, 2 system control |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational on the read strobe |
| spk_out | output | 1 | Speaker drive |

## Verification
The bench builds the block with its default counter width of 16 bits. At that width the zero-count case takes a full 65536 gated ticks, short enough for the run to reach the rising output after the whole wrap and to check that it is still low one tick before. Small intervals of 1, 5, 256 and 300 cover the one-tick edge and the carry between the low and high byte. Directed cases cover gating pauses, re-arming after the output has risen, a tick that coincides with the high-byte write, and the status bit ignoring writes.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_LO,
        ST_WAIT_HI,
        ST_COUNT,
        ST_DONE
    } tmr_state_t;

    localparam logic [1:0] PORT_DATA = 2'd0;
    localparam logic [1:0] PORT_CTRL = 2'd1;
    localparam logic [1:0] PORT_SYS  = 2'd2;

    // channel 2, low then high byte, mode 0, binary
    localparam logic [7:0] CW_ARM = 8'hB0;

    localparam int SYS_GATE_BIT = 0;
    localparam int SYS_SPK_BIT  = 1;
    localparam int SYS_OUT_BIT  = 5;

endpackage

// File: rtl/ivt_regs.sv
module ivt_regs
    import ivt_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BYTE_W-1:0] bus_wdata,
    input  logic              out_lvl,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              ev_ctrl,
    output logic              ev_data,
    output logic [BYTE_W-1:0] lo_byte,
    output logic              gate,
    output logic              spk_en
);

    localparam logic [BYTE_W-1:0] OUT_MASK = BYTE_W'(1) << SYS_OUT_BIT;

    logic [BYTE_W-1:0] sys_q;
    logic [BYTE_W-1:0] lo_q;
    logic              sys_wr;

    assign sys_wr  = bus_wr && (bus_addr == PORT_SYS);
    assign ev_ctrl = bus_wr && (bus_addr == PORT_CTRL) && (bus_wdata == CW_ARM);
    assign ev_data = bus_wr && (bus_addr == PORT_DATA);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sys_q <= '0;
            lo_q  <= '0;
        end else begin
            if (sys_wr) begin
                sys_q <= bus_wdata & ~OUT_MASK;
            end
            if (ev_data) begin
                lo_q <= bus_wdata;
            end
        end
    end

    assign lo_byte = lo_q;
    assign gate    = sys_q[SYS_GATE_BIT];
    assign spk_en  = sys_q[SYS_SPK_BIT];

    always_comb begin
        bus_rdata = '0;
        if (bus_rd && (bus_addr == PORT_SYS)) begin
            bus_rdata = sys_q | (out_lvl ? OUT_MASK : '0);
        end
    end

    AST_SYS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_wr |=> $stable(sys_q)); // R9

endmodule

// File: rtl/ivt_counter.sv
module ivt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             cnt_is_one
);

    localparam int          FULL_W  = CNT_W + 1;
    localparam logic [FULL_W-1:0] WRAP_VAL = FULL_W'(1) << CNT_W;

    logic [FULL_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= (load_val == '0) ? WRAP_VAL : {1'b0, load_val};
        end else if (dec) begin
            cnt_q <= cnt_q - FULL_W'(1);
        end
    end

    assign cnt_is_one = (cnt_q == FULL_W'(1));

    AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load) |=> (cnt_q == $past(cnt_q) - FULL_W'(1))); // R4
    AST_ZERO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_val == '0) |=> (cnt_q == WRAP_VAL)); // R6
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !dec) |=> $stable(cnt_q)); // R5

endmodule

// File: rtl/ivt_fsm.sv
module ivt_fsm
    import ivt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ev_ctrl,
    input  logic       ev_data,
    input  logic       tick_en,
    input  logic       gate,
    input  logic       cnt_is_one,
    output logic       load,
    output logic       dec,
    output logic       out_lvl
);

    tmr_state_t state_q, state_d;
    logic       out_q;

    assign load = (state_q == ST_WAIT_HI) && ev_data;
    assign dec  = (state_q == ST_COUNT) && tick_en && gate && !ev_ctrl && !ev_data;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ev_ctrl) state_d = ST_WAIT_LO;
            end
            ST_WAIT_LO: begin
                if (ev_ctrl)      state_d = ST_WAIT_LO;
                else if (ev_data) state_d = ST_WAIT_HI;
            end
            ST_WAIT_HI: begin
                if (ev_ctrl)      state_d = ST_WAIT_LO;
                else if (ev_data) state_d = ST_COUNT;
            end
            ST_COUNT: begin
                if (ev_ctrl)                 state_d = ST_WAIT_LO;
                else if (ev_data)            state_d = ST_WAIT_HI;
                else if (dec && cnt_is_one)  state_d = ST_DONE;
            end
            ST_DONE: begin
                if (ev_ctrl)      state_d = ST_WAIT_LO;
                else if (ev_data) state_d = ST_WAIT_HI;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= 1'b0;
        else        out_q <= (state_d == ST_DONE);
    end

    assign out_lvl = out_q;

    AST_CTRL_DROPS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        ev_ctrl |=> !out_q); // R2
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_q && !ev_ctrl && !ev_data) |=> out_q); // R7
    AST_GATE_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate && !out_q) |=> !out_q); // R5
    AST_DATA_DROPS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_data && state_q != ST_IDLE) |=> !out_q); // R7

endmodule

// File: rtl/interval_timer.sv
module interval_timer
    import ivt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic [1:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       spk_out
);

    localparam int BYTE_W = 8;

    logic              ev_ctrl;
    logic              ev_data;
    logic [BYTE_W-1:0] lo_byte;
    logic              gate;
    logic              spk_en;
    logic              out_lvl;
    logic              load;
    logic              dec;
    logic              cnt_is_one;
    logic [2*BYTE_W-1:0] raw_cnt;
    logic [CNT_W-1:0]  load_val;

    assign raw_cnt  = {bus_wdata, lo_byte};
    assign load_val = CNT_W'(raw_cnt);

    ivt_regs #(.BYTE_W(BYTE_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .out_lvl   (out_lvl),
        .bus_rdata (bus_rdata),
        .ev_ctrl   (ev_ctrl),
        .ev_data   (ev_data),
        .lo_byte   (lo_byte),
        .gate      (gate),
        .spk_en    (spk_en)
    );

    ivt_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_ctrl    (ev_ctrl),
        .ev_data    (ev_data),
        .tick_en    (tick_en),
        .gate       (gate),
        .cnt_is_one (cnt_is_one),
        .load       (load),
        .dec        (dec),
        .out_lvl    (out_lvl)
    );

    ivt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .load_val   (load_val),
        .dec        (dec),
        .cnt_is_one (cnt_is_one)
    );

    assign spk_out = out_lvl & spk_en;

    AST_SPK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !spk_en |-> !spk_out); // R8

endmodule

// File: tb/test_interval_timer.sv
module test_interval_timer;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 7;
    // count, ticks applied, expected output level
    localparam int VEC [NVEC][3] = '{
        '{5, 4, 0}, '{5, 5, 1}, '{1, 0, 0}, '{1, 1, 1},
        '{300, 299, 0}, '{300, 300, 1}, '{256, 256, 1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       spk_out;

    int checks = 0;
    int failures = 0;
    logic [7:0] rv;

    always #(CLK_PERIOD/2) clk = ~clk;

    interval_timer i_interval_timer (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .spk_out(spk_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic tk);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1; tick_en = tk;
        @(negedge clk);
        bus_wr = 1'b0; tick_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        for (int i = 0; i < n; i++) begin
            tick_en = 1'b1;
            @(negedge clk);
        end
        tick_en = 1'b0;
    endtask

    function automatic int outbit(input logic [7:0] v);
        return int'(v[5]);
    endfunction

    task automatic arm(input int cnt);
        wr(2'd1, 8'hB0, 1'b0);
        wr(2'd0, cnt[7:0], 1'b0);
        wr(2'd0, cnt[15:8], 1'b0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd2, rv);
        chk("R1 sys read", rv, 8'h00);
        chk("R1 speaker", spk_out, 0);

        // R3 data writes before any control word
        wr(2'd2, 8'h01, 1'b0);
        wr(2'd0, 8'h02, 1'b0);
        wr(2'd0, 8'h00, 1'b0);
        ticks(5);
        rd(2'd2, rv);
        chk("R3 unarmed data ignored", outbit(rv), 0);

        // R4 table walk
        for (int v = 0; v < NVEC; v++) begin
            arm(VEC[v][0]);
            ticks(VEC[v][1]);
            rd(2'd2, rv);
            chk($sformatf("R4 vec%0d", v), outbit(rv), VEC[v][2]);
        end

        // R7 output holds high, then low-byte write halts
        ticks(10);
        rd(2'd2, rv);
        chk("R7 hold high", outbit(rv), 1);
        wr(2'd0, 8'h03, 1'b0);
        rd(2'd2, rv);
        chk("R7 low byte drops out", outbit(rv), 0);
        ticks(8);
        wr(2'd0, 8'h00, 1'b0);
        ticks(2);
        rd(2'd2, rv);
        chk("R7 halted until high byte", outbit(rv), 0);
        ticks(1);
        rd(2'd2, rv);
        chk("R7 count after reload", outbit(rv), 1);

        // R2 foreign control value ignored, valid one drops out
        wr(2'd1, 8'h34, 1'b0);
        rd(2'd2, rv);
        chk("R2 other control ignored", outbit(rv), 1);
        wr(2'd1, 8'hB0, 1'b0);
        rd(2'd2, rv);
        chk("R2 arm drops out", outbit(rv), 0);

        // R4 tick coinciding with high byte is not counted
        wr(2'd0, 8'h04, 1'b0);
        wr(2'd0, 8'h00, 1'b1);
        ticks(3);
        rd(2'd2, rv);
        chk("R4 same-cycle tick", outbit(rv), 0);
        ticks(1);
        rd(2'd2, rv);
        chk("R4 fourth tick", outbit(rv), 1);

        // R5 gate pause
        arm(10);
        wr(2'd2, 8'h00, 1'b0);
        ticks(20);
        wr(2'd2, 8'h01, 1'b0);
        ticks(9);
        rd(2'd2, rv);
        chk("R5 paused", outbit(rv), 0);
        ticks(1);
        rd(2'd2, rv);
        chk("R5 resumed", outbit(rv), 1);

        // R8 speaker
        chk("R8 speaker off", spk_out, 0);
        wr(2'd2, 8'h03, 1'b0);
        chk("R8 speaker on", spk_out, 1);
        wr(2'd1, 8'hB0, 1'b0);
        chk("R8 speaker follows out", spk_out, 0);

        // R9 readback and read-only status bit
        wr(2'd2, 8'hDD, 1'b0);
        rd(2'd2, rv);
        chk("R9 readback", rv, 8'hDD);
        wr(2'd2, 8'h21, 1'b0);
        rd(2'd2, rv);
        chk("R9 status write ignored", rv, 8'h01);

        // R10 other ports and idle bus
        rd(2'd0, rv);
        chk("R10 data port read", rv, 8'h00);
        rd(2'd1, rv);
        chk("R10 control port read", rv, 8'h00);
        #1 chk("R10 idle bus", bus_rdata, 8'h00);

        // R6 zero count = 65536
        arm(0);
        ticks(65535);
        rd(2'd2, rv);
        chk("R6 one before wrap", outbit(rv), 0);
        ticks(1);
        rd(2'd2, rv);
        chk("R6 at 65536", outbit(rv), 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule